// File: doc/BRIEF.md
# ATM Cell Stream Framer

This block frames ATM cells in both directions between an internal word stream and a cell port of the kind used towards a PHY or switch fabric. On the transmit side it accepts the four header bytes and the 48 payload bytes of each cell. It computes the header check byte and inserts it directly after the header. It can also put a routing tag of configurable length in front of the cell, so the cell can be steered through a switch matrix. The tag contents come from a sideband input that belongs to the cell being sent.

On the receive side the block takes cells that start with a start-of-cell strobe. It drops the routing tag and recomputes the header check. If checking is enabled and the check fails, the whole cell is discarded and a saturating error counter is bumped. Otherwise it forwards the header, with its own start-of-cell mark, followed by the payload. The header is held inside the block until its check byte has been seen, so a rejected cell never produces a single output word. The port is 16 bits wide or 8 bits wide, chosen at run time. A 52-byte cell format leaves the check byte out in both directions. All edges use valid/ready handshakes, and configuration is held constant while a cell is in flight.

Top module: `atm_cell_framer`

## Requirements
- R1: A transmitted cell is, in order: the tag words, the header words, one check word (absent in 52-byte mode), then the payload words. In 16-bit mode there are 2 header words and 24 payload words; in 8-bit mode there are 4 header words and 48 payload words.
- R2: The check byte is the CRC-8 with generator x^8+x^2+x+1, starting from zero and taken most significant bit first over the four header bytes, then XORed with 0x55. In 16-bit mode the first byte of a word is bits 15:8, the check byte goes in bits 15:8 of its word and bits 7:0 are zero. In 8-bit mode the data sits in bits 7:0 and bits 15:8 of the outputs are driven zero.
- R3: With `cfgNoHec` set, no check word is sent on transmit and none is expected on receive, so the payload follows the header directly.
- R4: `cfgTagWords` sets 0 to TAG_MAX tag words per cell, and larger values act as TAG_MAX. Tag word k is `txTag[16k+15:16k]` (its low byte in 8-bit mode), taken when that word is transferred. Tag words appear on the output only while the cell's first header word is offered at the input.
- R5: `txOutSoc` is high with the first word of each transmitted cell, which is the first tag word if a tag is configured and the first header word otherwise, and low for every other word.
- R6: A word moves on a clock edge where valid and ready are both high. `txInReady` is low while tag or check words are being sent, and no input word is lost or repeated under any pattern of backpressure.
- R7: On receive, the tag words and the check word are consumed and not forwarded. The header words and then the payload words are output, with `rxOutSoc` high on the first header word only.
- R8: With `cfgHecCheck` set, a received cell whose check byte does not match produces no output words, and `rxErrCount` rises by one, saturating at 2^ERR_W-1.
- R9: With `cfgHecCheck` clear, received cells are forwarded whatever their check byte, and `rxErrCount` does not change.
- R10: While the receiver waits for a new cell, input words without `rxInSoc` are accepted and discarded.
- R11: After reset no output is valid, `rxErrCount` is zero and both framers expect the start of a cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWide | input | 1 | 1: 16-bit words, 0: 8-bit words |
| cfgNoHec | input | 1 | 52-byte cells without check byte |
| cfgHecCheck | input | 1 | Enable receive header check and discard |
| cfgTagWords | input | $clog2(TAG_MAX+1) | Routing tag length in words |
| txInData | input | 16 | Transmit header/payload word |
| txInValid | input | 1 | Transmit input word valid |
| txInReady | output | 1 | Transmit input word accepted |
| txTag | input | 16*TAG_MAX | Routing tag of the pending cell |
| txOutData | output | 16 | Cell port transmit word |
| txOutValid | output | 1 | Cell port transmit word valid |
| txOutReady | input | 1 | Cell port ready for a word |
| txOutSoc | output | 1 | First word of a transmitted cell |
| rxInData | input | 16 | Cell port receive word |
| rxInValid | input | 1 | Receive word valid |
| rxInReady | output | 1 | Receive word accepted |
| rxInSoc | input | 1 | First word of a received cell |
| rxOutData | output | 16 | Forwarded header/payload word |
| rxOutValid | output | 1 | Forwarded word valid |
| rxOutReady | input | 1 | Downstream ready |
| rxOutSoc | output | 1 | First header word of a forwarded cell |
| rxErrCount | output | ERR_W | Saturating count of discarded cells |

## Verification
Two pairs of events can fall on the same cycle. The first pair is a check failure and a counter that is already at its ceiling. The bench uses a 3-bit counter and sends a run of cells that are mostly corrupted, so the discard happens while the count sits at 7. The count must then stay at 7 while every word of the cell is still swallowed. The second pair is the replay of a held header and a payload word already waiting at the receive input. Random stalls on both sides of each handshake make these meet, and a behavioural model compares every transferred word, and its start-of-cell flag, against queues built from the requirements.

// File: rtl/cf_pkg.sv
package cf_pkg;

  localparam int WordW   = 16;
  localparam int HdrMax  = 4;                 // header words in 8-bit mode
  localparam int IdxW    = $clog2(HdrMax);    // index into tag or header words
  localparam logic [7:0] HecCoset = 8'h55;

  typedef enum logic [1:0] {
    RG_TAG = 2'd0,
    RG_HDR = 2'd1,
    RG_HEC = 2'd2,
    RG_PAY = 2'd3
  } region_e;

  // control to datapath, transmit side
  typedef struct packed {
    region_e         region;
    logic [IdxW-1:0] idx;     // word index inside the tag or header region
    logic            fire;    // output word moves this cycle
  } txStrobe_t;

  // control to datapath, receive side
  typedef struct packed {
    logic            hdrWr;   // store a header word and fold it into the CRC
    logic [IdxW-1:0] idx;
    logic            replay;  // output is driven from the header store
    logic [IdxW-1:0] rdIdx;
    logic            errInc;  // count one discarded cell
  } rxStrobe_t;

  function automatic logic [7:0] crc8Byte(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c ^ b;
    for (int i = 0; i < 8; i++) begin
      r = r[7] ? ({r[6:0], 1'b0} ^ 8'h07) : {r[6:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [7:0] crcWord(input logic [7:0] c, input logic [WordW-1:0] d,
                                         input logic wide);
    return wide ? crc8Byte(crc8Byte(c, d[15:8]), d[7:0]) : crc8Byte(c, d[7:0]);
  endfunction

endpackage

// File: rtl/cf_ctrl.sv
module cf_ctrl
  import cf_pkg::*;
#(
  parameter int TAG_MAX = 4,
  parameter int TW      = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWide,
  input  logic          cfgNoHec,
  input  logic          cfgHecCheck,
  input  logic [TW-1:0] cfgTagWords,
  input  logic          txInValid,
  output logic          txInReady,
  output logic          txOutValid,
  input  logic          txOutReady,
  output logic          txOutSoc,
  input  logic          rxInValid,
  input  logic          rxInSoc,
  output logic          rxInReady,
  output logic          rxOutValid,
  input  logic          rxOutReady,
  output logic          rxOutSoc,
  input  logic          hecBad,
  output txStrobe_t     txStb,
  output rxStrobe_t     rxStb
);

  localparam int MaxCell = TAG_MAX + HdrMax + 1 + 48;
  localparam int PosW    = $clog2(MaxCell + 1);
  typedef logic [PosW-1:0] pos_t;

  pos_t tagN, hdrN, payN, hdrBase, hecBase, payBase, lastPos;

  always_comb begin
    tagN    = (int'(cfgTagWords) > TAG_MAX) ? pos_t'(TAG_MAX) : pos_t'(cfgTagWords);
    hdrN    = cfgWide ? pos_t'(2) : pos_t'(4);
    payN    = cfgWide ? pos_t'(24) : pos_t'(48);
    hdrBase = tagN;
    hecBase = hdrBase + hdrN;
    payBase = cfgNoHec ? hecBase : hecBase + pos_t'(1);
    lastPos = payBase + payN - pos_t'(1);
  end

  function automatic region_e regionOf(input pos_t p, input pos_t hb, input pos_t cb,
                                       input pos_t pb);
    if (p < hb) return RG_TAG;
    if (p < cb) return RG_HDR;
    if (p < pb) return RG_HEC;
    return RG_PAY;
  endfunction

  // ---------------- transmit ----------------
  pos_t    txPos;
  region_e txReg;
  logic    txFire;

  assign txReg = regionOf(txPos, hdrBase, hecBase, payBase);

  always_comb begin
    unique case (txReg)
      RG_TAG:  begin txOutValid = txInValid; txInReady = 1'b0;       end
      RG_HEC:  begin txOutValid = 1'b1;      txInReady = 1'b0;       end
      default: begin txOutValid = txInValid; txInReady = txOutReady; end
    endcase
  end

  assign txFire   = txOutValid && txOutReady;
  assign txOutSoc = (txPos == '0);

  always_ff @(posedge clk) begin
    if (!rstN)       txPos <= '0;
    else if (txFire) txPos <= (txPos == lastPos) ? '0 : txPos + pos_t'(1);
  end

  assign txStb.region = txReg;
  assign txStb.idx    = (txReg == RG_TAG) ? IdxW'(txPos) : IdxW'(txPos - hdrBase);
  assign txStb.fire   = txFire;

  // ---------------- receive ----------------
  pos_t            rxPos;
  region_e         rxReg;
  logic [IdxW-1:0] rxIdx, rpIdx;
  logic            replaying, dropping;
  logic            rxAdvance, hdrDone, cellBad;

  assign rxReg = regionOf(rxPos, hdrBase, hecBase, payBase);
  assign rxIdx = IdxW'(rxPos - hdrBase);

  always_comb begin
    rxInReady  = 1'b0;
    rxOutValid = 1'b0;
    rxOutSoc   = 1'b0;
    if (replaying) begin
      rxOutValid = 1'b1;
      rxOutSoc   = (rpIdx == '0);
    end else if (rxReg == RG_PAY) begin
      rxInReady  = dropping ? 1'b1 : rxOutReady;
      rxOutValid = dropping ? 1'b0 : rxInValid;
    end else begin
      rxInReady  = 1'b1;
    end
  end

  // a word at position zero only counts when it carries the start strobe
  assign rxAdvance = rxInValid && rxInReady && (rxPos != '0 || rxInSoc);
  assign hdrDone   = rxAdvance && ((rxReg == RG_HEC) ||
                     (rxReg == RG_HDR && cfgNoHec && rxIdx == IdxW'(hdrN - pos_t'(1))));
  assign cellBad   = rxAdvance && rxReg == RG_HEC && cfgHecCheck && hecBad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxPos     <= '0;
      replaying <= 1'b0;
      rpIdx     <= '0;
      dropping  <= 1'b0;
    end else begin
      if (rxAdvance) rxPos <= (rxPos == lastPos) ? '0 : rxPos + pos_t'(1);
      if (rxAdvance && rxPos == lastPos) dropping <= 1'b0;
      else if (cellBad)                  dropping <= 1'b1;
      if (hdrDone && !cellBad) begin
        replaying <= 1'b1;
        rpIdx     <= '0;
      end else if (replaying && rxOutReady) begin
        if (rpIdx == IdxW'(hdrN - pos_t'(1))) replaying <= 1'b0;
        else                                  rpIdx     <= rpIdx + IdxW'(1);
      end
    end
  end

  assign rxStb.hdrWr  = rxAdvance && rxReg == RG_HDR;
  assign rxStb.idx    = rxIdx;
  assign rxStb.replay = replaying;
  assign rxStb.rdIdx  = rpIdx;
  assign rxStb.errInc = cellBad;

  // ---------------- assertions ----------------
  assert_soc_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    (txFire && txOutSoc) |=> !txOutSoc);

  assert_pay_after_hec_R1: assert property (@(posedge clk) disable iff (!rstN)
    (txFire && txReg == RG_HEC) |=> (txReg == RG_PAY));

  assert_replay_starts_soc_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(replaying) |-> (rxOutValid && rxOutSoc));

  assert_bad_cell_dropped_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxStb.errInc |=> (dropping && !rxOutValid));

endmodule

// File: rtl/cf_dpath.sv
module cf_dpath
  import cf_pkg::*;
#(
  parameter int TAG_MAX = 4,
  parameter int ERR_W   = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgWide,
  input  txStrobe_t                txStb,
  input  rxStrobe_t                rxStb,
  input  logic [WordW-1:0]         txInData,
  input  logic [TAG_MAX*WordW-1:0] txTag,
  output logic [WordW-1:0]         txOutData,
  input  logic [WordW-1:0]         rxInData,
  output logic [WordW-1:0]         rxOutData,
  output logic                     hecBad,
  output logic [ERR_W-1:0]         rxErrCount
);

  localparam logic [ERR_W-1:0] ErrTop = {ERR_W{1'b1}};

  // ---------------- transmit ----------------
  logic [WordW-1:0] tagWord [TAG_MAX];
  for (genvar g = 0; g < TAG_MAX; g++) begin : g_tag
    assign tagWord[g] = txTag[g*WordW +: WordW];
  end

  logic [7:0]       txCrc, txHec;
  logic [WordW-1:0] txWord;

  always_ff @(posedge clk) begin
    if (!rstN) txCrc <= '0;
    else if (txStb.fire && txStb.region == RG_HDR)
      txCrc <= crcWord((txStb.idx == '0) ? 8'h00 : txCrc, txInData, cfgWide);
  end

  assign txHec = txCrc ^ HecCoset;

  always_comb begin
    unique case (txStb.region)
      RG_TAG:  txWord = tagWord[txStb.idx];
      RG_HEC:  txWord = cfgWide ? {txHec, 8'h00} : {8'h00, txHec};
      default: txWord = txInData;
    endcase
    txOutData = cfgWide ? txWord : {8'h00, txWord[7:0]};
  end

  // ---------------- receive ----------------
  logic [7:0]       rxCrc, rxHecIn;
  logic [WordW-1:0] hdrBuf [HdrMax];
  logic [WordW-1:0] rxLane;
  logic [ERR_W-1:0] errCnt;

  assign rxLane = cfgWide ? rxInData : {8'h00, rxInData[7:0]};

  always_ff @(posedge clk) begin
    if (!rstN) rxCrc <= '0;
    else if (rxStb.hdrWr)
      rxCrc <= crcWord((rxStb.idx == '0) ? 8'h00 : rxCrc, rxInData, cfgWide);
  end

  always_ff @(posedge clk) begin
    if (rxStb.hdrWr) hdrBuf[rxStb.idx] <= rxLane;
  end

  assign rxHecIn   = cfgWide ? rxInData[15:8] : rxInData[7:0];
  assign hecBad    = (rxHecIn != (rxCrc ^ HecCoset));
  assign rxOutData = rxStb.replay ? hdrBuf[rxStb.rdIdx] : rxLane;

  always_ff @(posedge clk) begin
    if (!rstN)                           errCnt <= '0;
    else if (rxStb.errInc && errCnt != ErrTop) errCnt <= errCnt + ERR_W'(1);
  end

  assign rxErrCount = errCnt;

  // ---------------- assertions ----------------
  assert_err_saturates_R8: assert property (@(posedge clk) disable iff (!rstN)
    (errCnt == ErrTop) |=> (errCnt == ErrTop));

  assert_err_only_on_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rxStb.errInc |=> $stable(errCnt));

  assert_hec_pad_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWide && txStb.region == RG_HEC) |-> (txOutData[7:0] == 8'h00));

  assert_narrow_upper_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWide |-> (txOutData[15:8] == 8'h00 && rxOutData[15:8] == 8'h00));

endmodule

// File: rtl/atm_cell_framer.sv
module atm_cell_framer
  import cf_pkg::*;
#(
  parameter int TAG_MAX = 4,     // 2..4 tag words
  parameter int ERR_W   = 8,
  localparam int TW     = $clog2(TAG_MAX + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgWide,
  input  logic                     cfgNoHec,
  input  logic                     cfgHecCheck,
  input  logic [TW-1:0]            cfgTagWords,
  input  logic [15:0]              txInData,
  input  logic                     txInValid,
  output logic                     txInReady,
  input  logic [TAG_MAX*16-1:0]    txTag,
  output logic [15:0]              txOutData,
  output logic                     txOutValid,
  input  logic                     txOutReady,
  output logic                     txOutSoc,
  input  logic [15:0]              rxInData,
  input  logic                     rxInValid,
  output logic                     rxInReady,
  input  logic                     rxInSoc,
  output logic [15:0]              rxOutData,
  output logic                     rxOutValid,
  input  logic                     rxOutReady,
  output logic                     rxOutSoc,
  output logic [ERR_W-1:0]         rxErrCount
);

  txStrobe_t txStb;
  rxStrobe_t rxStb;
  logic      hecBad;

  cf_ctrl #(.TAG_MAX(TAG_MAX), .TW(TW)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWide(cfgWide), .cfgNoHec(cfgNoHec), .cfgHecCheck(cfgHecCheck),
    .cfgTagWords(cfgTagWords),
    .txInValid(txInValid), .txInReady(txInReady),
    .txOutValid(txOutValid), .txOutReady(txOutReady), .txOutSoc(txOutSoc),
    .rxInValid(rxInValid), .rxInSoc(rxInSoc), .rxInReady(rxInReady),
    .rxOutValid(rxOutValid), .rxOutReady(rxOutReady), .rxOutSoc(rxOutSoc),
    .hecBad(hecBad), .txStb(txStb), .rxStb(rxStb)
  );

  cf_dpath #(.TAG_MAX(TAG_MAX), .ERR_W(ERR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .cfgWide(cfgWide),
    .txStb(txStb), .rxStb(rxStb),
    .txInData(txInData), .txTag(txTag), .txOutData(txOutData),
    .rxInData(rxInData), .rxOutData(rxOutData),
    .hecBad(hecBad), .rxErrCount(rxErrCount)
  );

endmodule

// File: tb/atm_cell_framer_tb.sv
module atm_cell_framer_tb;

  localparam int TAG_MAX = 4;
  localparam int ERR_W   = 3;
  localparam int TW      = $clog2(TAG_MAX + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, cfgWide, cfgNoHec, cfgHecCheck;
  logic [TW-1:0] cfgTagWords;
  logic [15:0] txInData, txOutData, rxInData, rxOutData;
  logic txInValid, txInReady, txOutValid, txOutReady, txOutSoc;
  logic rxInValid, rxInReady, rxInSoc, rxOutValid, rxOutReady, rxOutSoc;
  logic [TAG_MAX*16-1:0] txTag;
  logic [ERR_W-1:0] rxErrCount;

  atm_cell_framer #(.TAG_MAX(TAG_MAX), .ERR_W(ERR_W)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWide(cfgWide), .cfgNoHec(cfgNoHec),
    .cfgHecCheck(cfgHecCheck), .cfgTagWords(cfgTagWords),
    .txInData(txInData), .txInValid(txInValid), .txInReady(txInReady), .txTag(txTag),
    .txOutData(txOutData), .txOutValid(txOutValid), .txOutReady(txOutReady),
    .txOutSoc(txOutSoc),
    .rxInData(rxInData), .rxInValid(rxInValid), .rxInReady(rxInReady), .rxInSoc(rxInSoc),
    .rxOutData(rxOutData), .rxOutValid(rxOutValid), .rxOutReady(rxOutReady),
    .rxOutSoc(rxOutSoc), .rxErrCount(rxErrCount)
  );

  int total = 0;
  int bad   = 0;
  int errExp;

  logic [16:0]           txSrc[$];
  logic [TAG_MAX*16-1:0] txSrcTag[$];
  logic [16:0]           txExp[$];
  logic [16:0]           rxSrc[$];
  logic [16:0]           rxExp[$];

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // reference check byte: bit-serial CRC-8, generator 0x07, then coset
  function automatic logic [7:0] refHec(input logic [31:0] h);
    logic [7:0] c = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      logic fb;
      fb = c[7] ^ h[i];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c ^ 8'h55;
  endfunction

  function automatic logic [15:0] lane(input bit wide, input logic [15:0] w);
    return wide ? w : {8'h00, w[7:0]};
  endfunction

  task automatic buildCell(input bit wide, input bit noHec, input int tagN, input bit chkOn,
                           input bit corrupt);
    logic [31:0] h;
    logic [TAG_MAX*16-1:0] tg;
    logic [7:0] hc;
    logic [15:0] w;
    int hdrN, payN;
    bit first, drop;
    h    = $urandom;
    tg   = {$urandom, $urandom};
    hc   = refHec(h);
    hdrN = wide ? 2 : 4;
    payN = wide ? 24 : 48;
    // transmit source and expected stream (R1 R2 R3 R4 R5)
    first = 1'b1;
    for (int k = 0; k < tagN; k++) begin
      txExp.push_back({first, lane(wide, tg[16*k +: 16])});
      first = 1'b0;
    end
    for (int k = 0; k < hdrN; k++) begin
      w = wide ? h[31-16*k -: 16] : {8'($urandom), h[31-8*k -: 8]};
      txSrc.push_back({1'b0, w}); txSrcTag.push_back(tg);
      txExp.push_back({first, lane(wide, w)});
      first = 1'b0;
    end
    if (!noHec) txExp.push_back({1'b0, wide ? {hc, 8'h00} : {8'h00, hc}});
    for (int k = 0; k < payN; k++) begin
      w = 16'($urandom);
      txSrc.push_back({1'b0, w}); txSrcTag.push_back(tg);
      txExp.push_back({1'b0, lane(wide, w)});
    end
    // receive: idle words without start strobe first (R10)
    for (int k = 0; k < int'($urandom % 3); k++) rxSrc.push_back({1'b0, 16'($urandom)});
    first = 1'b1;
    for (int k = 0; k < tagN; k++) begin
      rxSrc.push_back({first, 16'($urandom)});
      first = 1'b0;
    end
    drop = !noHec && chkOn && corrupt;
    if (drop && errExp < (1 << ERR_W) - 1) errExp++;
    for (int k = 0; k < hdrN; k++) begin
      w = wide ? h[31-16*k -: 16] : {8'($urandom), h[31-8*k -: 8]};
      rxSrc.push_back({first, w});
      if (!drop) rxExp.push_back({k == 0, lane(wide, w)});
      first = 1'b0;
    end
    if (!noHec) begin
      logic [7:0] sent = corrupt ? (hc ^ 8'h01) : hc;
      rxSrc.push_back({1'b0, wide ? {sent, 8'($urandom)} : {8'($urandom), sent}});
    end
    for (int k = 0; k < payN; k++) begin
      w = 16'($urandom);
      rxSrc.push_back({1'b0, w});
      if (!drop) rxExp.push_back({1'b0, lane(wide, w)});
    end
  endtask

  task automatic drive();
    if (txSrc.size() > 0) begin
      txInData = txSrc[0][15:0];
      txTag    = txSrcTag[0];
    end
    if (rxSrc.size() > 0) begin
      rxInData = rxSrc[0][15:0];
      rxInSoc  = rxSrc[0][16];
    end
  endtask

  task automatic runPhase(input bit wide, input bit noHec, input bit chkOn, input int tagCfg,
                          input int nCells, input int nBad);
    int tagN, wd;
    bit txInF, rxInF, txOutF, rxOutF;
    tagN = (tagCfg > TAG_MAX) ? TAG_MAX : tagCfg;
    @(posedge clk); #1;
    rstN = 1'b0; txInValid = 1'b0; rxInValid = 1'b0; txOutReady = 1'b0; rxOutReady = 1'b0;
    cfgWide = wide; cfgNoHec = noHec; cfgHecCheck = chkOn; cfgTagWords = TW'(tagCfg);
    errExp = 0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(!txOutValid && !rxOutValid, "R11 outputs idle after reset",
        {txOutValid, rxOutValid}, 0);
    chk(rxErrCount == 0, "R11 error count after reset", rxErrCount, 0);
    chk(txOutSoc == 1'b1, "R11 transmit waits for cell start", txOutSoc, 1);
    for (int c = 0; c < nCells; c++) buildCell(wide, noHec, tagN, chkOn, c < nBad);
    @(posedge clk); #1;
    drive();
    wd = 0;
    while (txSrc.size() > 0 || rxSrc.size() > 0 || txExp.size() > 0 || rxExp.size() > 0) begin
      @(negedge clk);
      txInF  = txInValid && txInReady;
      rxInF  = rxInValid && rxInReady;
      txOutF = txOutValid && txOutReady;
      rxOutF = rxOutValid && rxOutReady;
      if (txOutF) begin
        if (txExp.size() == 0) chk(1'b0, "R1 extra transmit word", txOutData, 0);
        else begin
          logic [16:0] e = txExp.pop_front();
          chk({txOutSoc, txOutData} == e, "R1 R2 R3 R4 R5 R6 transmit word",
              {txOutSoc, txOutData}, e);
        end
      end
      if (rxOutF) begin
        if (rxExp.size() == 0) chk(1'b0, "R8 extra receive word", rxOutData, 0);
        else begin
          logic [16:0] e = rxExp.pop_front();
          chk({rxOutSoc, rxOutData} == e, "R3 R7 R9 R10 receive word",
              {rxOutSoc, rxOutData}, e);
        end
      end
      if (txInF && txSrc.size() == 0) chk(1'b0, "R6 transmit input over-read", 0, 0);
      @(posedge clk); #1;
      if (txInF && txSrc.size() > 0) begin
        void'(txSrc.pop_front());
        void'(txSrcTag.pop_front());
      end
      if (rxInF && rxSrc.size() > 0) void'(rxSrc.pop_front());
      if (!txInValid || txInF) txInValid = (txSrc.size() > 0) && ($urandom % 4 != 0);
      if (!rxInValid || rxInF) rxInValid = (rxSrc.size() > 0) && ($urandom % 4 != 0);
      txOutReady = ($urandom % 4 != 0);
      rxOutReady = ($urandom % 3 != 0);
      drive();
      wd++;
      if (wd > 20000) begin
        chk(1'b0, "watchdog expired", wd, 0);
        txSrc.delete(); txSrcTag.delete(); rxSrc.delete(); txExp.delete(); rxExp.delete();
        break;
      end
    end
    txInValid = 1'b0; rxInValid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!txOutValid && !rxOutValid, "R1 R7 no words left over", {txOutValid, rxOutValid}, 0);
    chk(rxErrCount == ERR_W'(errExp), chkOn ? "R8 error count" : "R9 error count unchanged",
        rxErrCount, errExp);
  endtask

  initial begin
    rstN = 1'b0; txInValid = 1'b0; rxInValid = 1'b0; txOutReady = 1'b0; rxOutReady = 1'b0;
    txInData = '0; rxInData = '0; rxInSoc = 1'b0; txTag = '0;
    cfgWide = 1'b1; cfgNoHec = 1'b0; cfgHecCheck = 1'b1; cfgTagWords = '0;
    runPhase(1'b1, 1'b0, 1'b1, 0, 6, 2);   // R1 R2 R8, no tag
    runPhase(1'b0, 1'b0, 1'b1, 2, 12, 10); // R8 saturation at 7, narrow
    runPhase(1'b1, 1'b1, 1'b1, 3, 5, 3);   // R3 52-byte, wide
    runPhase(1'b0, 1'b1, 1'b0, 1, 4, 2);   // R3 52-byte, narrow
    runPhase(1'b1, 1'b0, 1'b0, 5, 6, 3);   // R4 clamp to 4, R9 check off
    runPhase(1'b0, 1'b0, 1'b0, 4, 4, 2);   // R9 narrow, full tag
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule